// File: doc/BRIEF.md
# Dual-Mode Parallel Display Host Port

This block is the host-facing slave of a display controller. A microprocessor drives an 8-bit data bus and four control lines: chip select (active low), data/command select, a direction or write strobe, and an enable or read strobe. The block turns these bus cycles into single-cycle requests toward an internal display RAM port and toward the command register path. A strap input picks the bus style. In the first style one line gives the direction and a separate enable acts as the strobe. In the second style there are separate active-low read and write strobes.

All bus lines are sampled in the system clock domain through a two-flop synchronizer. Each transfer takes effect on the trailing edge of the active strobe. Writes with the select high go to display RAM at an internal address that steps up after each access. Writes with the select low become command bytes. Reads with the select low return a status byte from outside the block.

Reads with the select high pass through a one-byte pipeline. Each display read returns the byte fetched by the previous display read, then starts the next fetch. After reset, or after the command side reloads the address, the first display read is a dummy that returns 0x00.

Top module: `disp_host_port`

## Requirements
- R1: With `mode_8080`=0, a transfer takes place on the falling edge of `bus_e_rd` while `bus_cs_n` is low. `bus_rw_wr`=1 makes it a read and `bus_rw_wr`=0 makes it a write.
- R2: With `mode_8080`=1, a rising edge of `bus_rw_wr` (write strobe, active low) performs a write, and a rising edge of `bus_e_rd` (read strobe, active low) performs a read. Either edge counts only if `bus_cs_n` was low while the strobe was active.
- R3: Strobe activity while `bus_cs_n` is high produces no RAM access, no command byte, no output enable and no change of address.
- R4: A write with `bus_dc`=1 pulses `ram_we` for one cycle, with `ram_wdata` equal to the bus byte and `ram_addr` equal to the current address. The pulse is seen in the cycle after the third rising clock edge that follows the trailing strobe edge. The address then steps by one and wraps at 2^ADDR_W.
- R5: A write with `bus_dc`=0 pulses `cmd_valid` for one cycle with `cmd_data` equal to the bus byte, using the same latency as R4. The display address is left unchanged.
- R6: While a read strobe is active with `bus_dc`=0, `bus_data_o` equals `status_i`. The read makes no RAM access and leaves the address unchanged.
- R7: A read with `bus_dc`=1 pulses `ram_re` at the current address with the same latency as R4, and the address then steps by one. While the strobe is active, the bus carries the byte fetched by the previous display read.
- R8: The first display read after reset or after an address load is a dummy. The bus reads 0x00 during it.
- R9: `addr_load` high for one cycle sets the address to `addr_load_val` at the next clock edge and invalidates the read pipeline.
- R10: `bus_data_oe` is high only while `bus_cs_n` is low and a read strobe is active. In mode 0 that means `bus_e_rd`=1 and `bus_rw_wr`=1. In mode 1 it means `bus_e_rd`=0.
- R11: `ram_rdata` is captured two clock edges after the edge that raised `ram_re`, so the RAM has one cycle of read latency. The captured byte is held until the next capture.
- R12: After reset, `ram_we`, `ram_re`, `cmd_valid` and `bus_data_oe` are low and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_8080 | input | 1 | Bus style strap: 0 = enable plus direction, 1 = separate read and write strobes |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_dc | input | 1 | 1 = display data, 0 = command or status |
| bus_rw_wr | input | 1 | Mode 0: direction (1 = read). Mode 1: write strobe, active low |
| bus_e_rd | input | 1 | Mode 0: enable, active high. Mode 1: read strobe, active low |
| bus_data_i | input | 8 | Data bus, host to block |
| bus_data_o | output | 8 | Data bus, block to host |
| bus_data_oe | output | 1 | Output enable for the data bus pads |
| status_i | input | 8 | Status byte returned on status reads |
| addr_load | input | 1 | Address reload from the command path |
| addr_load_val | input | ADDR_W | New display address |
| ram_addr | output | ADDR_W | Display RAM access address |
| ram_we | output | 1 | Display RAM write pulse |
| ram_wdata | output | 8 | Display RAM write data |
| ram_re | output | 1 | Display RAM read pulse |
| ram_rdata | input | 8 | Display RAM read data, one cycle after `ram_re` |
| cmd_valid | output | 1 | Command byte pulse |
| cmd_data | output | 8 | Command byte |

## Verification
A RAM, command or read request is due in the cycle after the third rising edge that follows the trailing strobe edge. The bench changes pins just after a falling clock edge and records the expected request with that cycle number. On every falling edge it compares the three request pulses and their address and data against its queue, so a request that comes early or late fails. Read-back data and the output enable are combinational from the pins and the pipeline byte. They are sampled one time unit after a falling edge in the middle of the strobe. The bench leaves at least eight idle cycles between reads so that the one-cycle-latency fetch has landed before the next read.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;

    localparam int BUS_W = 8;

    // One synchronized sample of every bus pin
    typedef struct packed {
        logic             cs_n;
        logic             dc;
        logic             rw_wr;
        logic             e_rd;
        logic [BUS_W-1:0] data;
    } bus_smp_t;

    // Idle value: deselected, so no edge can qualify out of reset
    localparam bus_smp_t SMP_IDLE = '{cs_n: 1'b1, dc: 1'b0, rw_wr: 1'b0,
                                      e_rd: 1'b0, data: '0};

    // A decoded bus transfer, valid for one cycle
    typedef struct packed {
        logic             valid;
        logic             read;
        logic             dc;
        logic [BUS_W-1:0] data;
    } bus_evt_t;

endpackage

// File: rtl/disp_bus_sync.sv
module disp_bus_sync
    import disp_host_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bus_smp_t pin,
    output logic     cur_rw_wr,
    output logic     cur_e_rd,
    output bus_smp_t prev
);
    localparam int DEPTH = STAGES + 1;

    bus_smp_t [DEPTH-1:0] stg_d, stg_q;

    // stage 0 takes the raw pins, each further stage the one before it
    always_comb begin
        stg_d = {stg_q[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= {DEPTH{SMP_IDLE}};
        else        stg_q <= stg_d;
    end

    // last synchronizer stage is "now", the extra stage is "one cycle ago"
    assign cur_rw_wr = stg_q[STAGES-1].rw_wr;
    assign cur_e_rd  = stg_q[STAGES-1].e_rd;
    assign prev      = stg_q[STAGES];

endmodule

// File: rtl/disp_strobe_decode.sv
module disp_strobe_decode
    import disp_host_pkg::*;
(
    input  logic     mode_8080,
    input  logic     cur_rw_wr,
    input  logic     cur_e_rd,
    input  bus_smp_t prev,
    output bus_evt_t evt
);
    logic e_fall, wr_rise, rd_rise;

    always_comb begin
        e_fall  = prev.e_rd   & ~cur_e_rd  & ~prev.cs_n;
        wr_rise = ~prev.rw_wr & cur_rw_wr  & ~prev.cs_n;
        rd_rise = ~prev.e_rd  & cur_e_rd   & ~prev.cs_n;
        evt      = '0;
        evt.dc   = prev.dc;
        evt.data = prev.data;
        if (!mode_8080) begin
            evt.valid = e_fall;
            evt.read  = prev.rw_wr;
        end else begin
            evt.valid = wr_rise | rd_rise;
            evt.read  = ~wr_rise;          // write wins if both close together
        end
    end

endmodule

// File: rtl/disp_access_ctrl.sv
module disp_access_ctrl
    import disp_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_load_val,
    input  logic [BUS_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [BUS_W-1:0]  ram_wdata,
    output logic              ram_re,
    output logic              cmd_valid,
    output logic [BUS_W-1:0]  cmd_data,
    output logic [BUS_W-1:0]  rd_byte
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] acc_addr;
        logic              we;
        logic              re;
        logic              re_dly;
        logic [BUS_W-1:0]  wdata;
        logic              cmd_v;
        logic [BUS_W-1:0]  cmd_d;
        logic [BUS_W-1:0]  rdbuf;
        logic              rd_valid;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.we     = 1'b0;
        st_d.re     = 1'b0;
        st_d.cmd_v  = 1'b0;
        st_d.re_dly = st_q.re;
        // RAM answers one cycle after the request
        if (st_q.re_dly) begin
            st_d.rdbuf    = ram_rdata;
            st_d.rd_valid = 1'b1;
        end
        if (evt.valid) begin
            if (!evt.read) begin
                if (evt.dc) begin
                    st_d.we       = 1'b1;
                    st_d.acc_addr = st_q.addr;
                    st_d.wdata    = evt.data;
                    st_d.addr     = st_q.addr + ADDR_ONE;
                end else begin
                    st_d.cmd_v = 1'b1;
                    st_d.cmd_d = evt.data;
                end
            end else if (evt.dc) begin
                st_d.re       = 1'b1;
                st_d.acc_addr = st_q.addr;
                st_d.addr     = st_q.addr + ADDR_ONE;
            end
        end
        // reload drops the pipeline and any fetch still in flight
        if (addr_load) begin
            st_d.addr     = addr_load_val;
            st_d.rd_valid = 1'b0;
            st_d.re_dly   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ram_addr  = st_q.acc_addr;
    assign ram_we    = st_q.we;
    assign ram_wdata = st_q.wdata;
    assign ram_re    = st_q.re;
    assign cmd_valid = st_q.cmd_v;
    assign cmd_data  = st_q.cmd_d;
    assign rd_byte   = st_q.rd_valid ? st_q.rdbuf : '0;

    // R4: at most one request leaves per cycle
    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.we, st_q.re, st_q.cmd_v}));

    // R7: a RAM access leaves the address one past the accessed location
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.we || st_q.re) && !$past(addr_load) |-> st_q.addr == st_q.acc_addr + ADDR_ONE);

    // R5: a command byte does not move the address
    p_cmd_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cmd_v && !$past(addr_load) |-> st_q.addr == $past(st_q.addr));

    // R9: reload sets the address and empties the pipeline
    p_load_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_load) |-> !st_q.rd_valid && st_q.addr == $past(addr_load_val));

    // R11: the read buffer only changes on a capture
    p_rdbuf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.re_dly |=> $stable(st_q.rdbuf));

endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
    import disp_host_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_8080,
    input  logic              bus_cs_n,
    input  logic              bus_dc,
    input  logic              bus_rw_wr,
    input  logic              bus_e_rd,
    input  logic [7:0]        bus_data_i,
    output logic [7:0]        bus_data_o,
    output logic              bus_data_oe,
    input  logic [7:0]        status_i,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_load_val,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    output logic              ram_re,
    input  logic [7:0]        ram_rdata,
    output logic              cmd_valid,
    output logic [7:0]        cmd_data
);
    bus_smp_t         pin_smp, prev_smp;
    logic             cur_rw_wr, cur_e_rd;
    bus_evt_t         evt;
    logic [BUS_W-1:0] rd_byte;
    logic             rd_act;

    always_comb begin
        pin_smp.cs_n  = bus_cs_n;
        pin_smp.dc    = bus_dc;
        pin_smp.rw_wr = bus_rw_wr;
        pin_smp.e_rd  = bus_e_rd;
        pin_smp.data  = bus_data_i;
    end

    disp_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (pin_smp),
        .cur_rw_wr (cur_rw_wr),
        .cur_e_rd  (cur_e_rd),
        .prev      (prev_smp)
    );

    disp_strobe_decode u_decode (
        .mode_8080 (mode_8080),
        .cur_rw_wr (cur_rw_wr),
        .cur_e_rd  (cur_e_rd),
        .prev      (prev_smp),
        .evt       (evt)
    );

    disp_access_ctrl #(.ADDR_W(ADDR_W)) u_access (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt           (evt),
        .addr_load     (addr_load),
        .addr_load_val (addr_load_val),
        .ram_rdata     (ram_rdata),
        .ram_addr      (ram_addr),
        .ram_we        (ram_we),
        .ram_wdata     (ram_wdata),
        .ram_re        (ram_re),
        .cmd_valid     (cmd_valid),
        .cmd_data      (cmd_data),
        .rd_byte       (rd_byte)
    );

    // pads drive only during an active, selected read strobe
    always_comb begin
        rd_act      = mode_8080 ? (~bus_cs_n & ~bus_e_rd)
                                : (~bus_cs_n & bus_e_rd & bus_rw_wr);
        bus_data_oe = rd_act;
        bus_data_o  = bus_dc ? rd_byte : status_i;
    end

endmodule

// File: tb/disp_host_port_bench.sv
module disp_host_port_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic          rst_n = 1'b0, mode_8080 = 1'b0;
    logic          bus_cs_n = 1'b1, bus_dc = 1'b0, bus_rw_wr = 1'b1, bus_e_rd = 1'b0;
    logic [7:0]    bus_data_i = '0, bus_data_o, status_i = '0;
    logic          bus_data_oe;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_load_val = '0, ram_addr;
    logic          ram_we, ram_re, cmd_valid;
    logic [7:0]    ram_wdata, ram_rdata = '0, cmd_data;

    disp_host_port #(.ADDR_W(AW)) u_disp_host_port (.*);

    int n_chk = 0, n_err = 0, cyc = 0;
    bit chk_en = 0, done = 0;
    string mtag = "R1";
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 11);
    endfunction

    // synchronous RAM with one cycle of read latency
    logic [7:0] mem [DEPTH];
    logic       init_req = 1'b0;
    always @(posedge clk) begin
        if (init_req) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
        end else begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            if (ram_re) ram_rdata <= mem[ram_addr];
        end
    end

    // behavioural model: address, pipeline byte, shadow contents
    logic [7:0] shadow [DEPTH];
    int         m_addr = 0;
    bit         m_valid = 0;
    logic [7:0] m_buf = '0;

    typedef struct { int due; int kind; int addr; int data; } exp_t; // kind 1 wr, 2 rd, 3 cmd
    exp_t eq[$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s/%s: actual=%0h expected=%0h", mtag, req, act, exp);
        end
    endtask

    // every cycle: request pulses must match the model exactly
    always @(negedge clk) begin
        if (chk_en) begin
            exp_t e;
            e = '{due: -1, kind: 0, addr: 0, data: 0};
            if (eq.size() > 0 && eq[0].due == cyc) e = eq.pop_front();
            chk("R4 ram_we pulse",   int'(ram_we),    int'(e.kind == 1));
            chk("R7 ram_re pulse",   int'(ram_re),    int'(e.kind == 2));
            chk("R5 cmd_valid pulse", int'(cmd_valid), int'(e.kind == 3));
            if (e.kind == 1 || e.kind == 2) chk("R9 access address", int'(ram_addr), e.addr);
            if (e.kind == 1) chk("R4 ram_wdata", int'(ram_wdata), e.data);
            if (e.kind == 3) chk("R5 cmd_data",  int'(cmd_data),  e.data);
        end
    end

    task automatic set_idle();
        bus_cs_n = 1'b1; bus_dc = 1'b0; bus_data_i = '0;
        bus_rw_wr = 1'b1; bus_e_rd = mode_8080;
    endtask

    task automatic host_write(logic dc, logic [7:0] d);
        @(negedge clk);
        bus_cs_n = 1'b0; bus_dc = dc; bus_data_i = d; bus_rw_wr = 1'b0;
        if (!mode_8080) bus_e_rd = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R10 no drive during write", int'(bus_data_oe), 0);
        @(negedge clk);
        if (mode_8080) bus_rw_wr = 1'b1; else bus_e_rd = 1'b0;
        eq.push_back('{due: cyc + 3, kind: dc ? 1 : 3, addr: m_addr, data: int'(d)});
        if (dc) begin
            shadow[m_addr] = d;
            m_addr = (m_addr + 1) % DEPTH;
        end
        @(negedge clk);
        set_idle();
        repeat (6) @(negedge clk);
    endtask

    task automatic host_read(logic dc);
        logic [7:0] exp;
        string      lbl;
        if (dc) begin
            exp = m_valid ? m_buf : 8'h00;
            lbl = m_valid ? "R7/R11 display read" : "R8 dummy read";
        end else begin
            exp = status_i;
            lbl = "R6 status read";
        end
        @(negedge clk);
        bus_cs_n = 1'b0; bus_dc = dc;
        if (mode_8080) bus_e_rd = 1'b0;
        else begin bus_rw_wr = 1'b1; bus_e_rd = 1'b1; end
        repeat (2) @(negedge clk);
        #1;
        chk("R10 drive during read", int'(bus_data_oe), 1);
        chk(lbl, int'(bus_data_o), int'(exp));
        @(negedge clk);
        bus_e_rd = ~bus_e_rd;
        if (dc) begin
            eq.push_back('{due: cyc + 3, kind: 2, addr: m_addr, data: 0});
            m_buf   = shadow[m_addr];
            m_valid = 1;
            m_addr  = (m_addr + 1) % DEPTH;
        end
        @(negedge clk);
        set_idle();
        repeat (8) @(negedge clk);
    endtask

    task automatic load_addr(int a);
        @(negedge clk);
        addr_load = 1'b1; addr_load_val = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
        m_addr = a; m_valid = 0;
        repeat (2) @(negedge clk);
    endtask

    // strobes with chip select high must do nothing
    task automatic stray_strobes();
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            bus_dc = 1'b1; bus_data_i = 8'hEE;
            if (mode_8080) begin
                if (k == 0) bus_rw_wr = 1'b0; else bus_e_rd = 1'b0;
            end else begin
                bus_rw_wr = (k == 1); bus_e_rd = 1'b1;
            end
            repeat (2) @(negedge clk);
            #1 chk("R3 no drive when deselected", int'(bus_data_oe), 0);
            @(negedge clk);
            set_idle();
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic run_mode(logic m);
        chk_en = 0;
        mode_8080 = m;
        mtag = m ? "R2" : "R1";
        set_idle();
        rst_n = 1'b0; init_req = 1'b1;
        for (int i = 0; i < DEPTH; i++) shadow[i] = pat(i);
        eq.delete(); m_addr = 0; m_valid = 0;
        repeat (3) @(negedge clk);
        init_req = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ram_we", int'(ram_we), 0);
        chk("R12 reset ram_re", int'(ram_re), 0);
        chk("R12 reset cmd_valid", int'(cmd_valid), 0);
        chk("R12 reset oe", int'(bus_data_oe), 0);
        chk_en = 1;
        host_read(1'b1);               // dummy from address 0
        host_read(1'b1);
        host_read(1'b1);
        status_i = m ? 8'h3C : 8'hA5;
        host_read(1'b0);
        host_read(1'b1);               // address untouched by status read
        load_addr(8'h10);
        host_write(1'b1, 8'h5A);
        host_write(1'b1, 8'hC3);
        host_write(1'b0, 8'h81);
        load_addr(8'h10);
        host_read(1'b1);
        host_read(1'b1);
        stray_strobes();
        host_read(1'b1);
        host_read(1'b1);
        load_addr(DEPTH - 2);          // wrap at the top of the address space
        host_read(1'b1);
        host_read(1'b1);
        host_read(1'b1);
        host_read(1'b1);
        host_write(1'b0, 8'h07);
        repeat (6) @(negedge clk);
        chk("R4 no leftover requests", eq.size(), 0);
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule